// File: doc/BRIEF.md
# Shadowed Four-Channel PWM Generator

This block produces four independent pulse-width-modulated outputs from a slow timebase. The timebase arrives as a one-cycle enable pulse on the system clock, nominally once per microsecond. Each channel divides that pulse by 1, 2, 4 or 8 and counts the divided steps. Its output is active for the first `duty` steps of a `period`-step frame. Software programs each channel through a small strobe-based register bus, with one period, one duty and one control word per channel.

Writes are never applied directly. They land in shadow registers. Writing the period word arms the channel. The armed period, duty and control values are then adopted together at the end of the frame that is running, so a waveform never mixes old and new settings. A period value of zero is a deferred stop: the channel completes its frame and then drives a constant low.

Each channel is controlled by a two-state machine:

- `CH_IDLE`: output low, no counting.
- `CH_RUN`: counting frames.

The transitions are:

- **start**: `CH_IDLE` to `CH_RUN`. Taken when a commit is pending and the shadow period is nonzero.
- **drop**: `CH_IDLE` to `CH_IDLE`. A pending commit whose shadow period is zero is discarded.
- **reload**: `CH_RUN` to `CH_RUN`. At the end of a frame with a commit pending, the shadow values are adopted.
- **stop**: `CH_RUN` to `CH_IDLE`. At the end of a frame with a pending zero period, the channel stops.
- **wrap**: `CH_RUN` to `CH_RUN`. At the end of a frame with nothing pending, the next frame starts with the same settings.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset every output is low and every channel register reads zero.
- R2: The register addresses are as follows. Period is at 0x400+4·c, duty at 0x420+4·c and control at 0x440+4·c, for channel c from 0 to 3. A read returns the last written value one cycle after the read strobe. Period and duty keep only data bits [15:0]. Control keeps bits [1:0] (divider select) and bit 5 (invert), and all its other bits read zero. Any other address reads zero.
- R3: Writing duty or control without a following period write leaves the running waveform unchanged.
- R4: A period write arms the channel. The shadow period, duty and control are then adopted together at the end of the running frame, and never in the middle of one.
- R5: Divider select d makes each count step last 2^d timebase pulses.
- R6: With period P and duty D, a frame lasts P steps. With normal polarity the output is high for the first min(D,P) steps and low for the rest. D=0 gives no high time, and D≥P gives a frame that is high throughout.
- R7: With the invert bit set, the active portion of each frame is driven low and the inactive portion high.
- R8: A committed zero period stops the channel at the end of the running frame. From then on the output stays low whatever the polarity.
- R9: An idle channel starts its first frame, active portion first, two clock cycles after the cycle in which its nonzero period write is accepted. It does not wait for a frame boundary.
- R10: Channels are independent. Writes to one channel never alter another channel's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase enable pulse |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pwm_out | output | 4 | Channel outputs, bit c for channel c |

## Verification
The bench goes after the commit point first. It changes duty and control without touching the period, which a design that applied shadows directly would show as altered high times. It also arms a new duty right at the start of a frame: a design that committed early would stretch that frame's high time instead of the next one's. It stops an inverted channel during its high phase, which catches both an immediate stop and a stop that leaves the output at the inverted idle level. Random frames across dividers, polarities and duty values of zero, below the period and above it expose prescaler off-by-ones and a wrong duty clamp, and register readback with junk in the unused bits exposes masking errors.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
    localparam int CW      = 16;  // period / duty width
    localparam int DIV_W   = 2;   // divider select width
    localparam int INV_BIT = 5;   // invert bit position in control word

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_t;

    typedef struct packed {
        logic [CW-1:0]    period;
        logic [CW-1:0]    duty;
        logic [DIV_W-1:0] div;
        logic             inv;
    } ch_cfg_t;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_shadow_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 12,
    parameter int DW  = 32,
    parameter logic [AW-1:0] PER_BASE = 12'h400,
    parameter logic [AW-1:0] DUT_BASE = 12'h420,
    parameter logic [AW-1:0] CTL_BASE = 12'h440
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output ch_cfg_t        cfg [NCH],
    output logic [NCH-1:0] arm
);
    localparam int STRIDE = 4;

    function automatic logic [AW-1:0] slot(input logic [AW-1:0] base, input int c);
        return base + AW'(STRIDE * c);
    endfunction

    logic [DW-1:0] rd_mux;
    logic          unused_hi;
    assign unused_hi = ^wdata[DW-1:CW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) cfg[c] <= '0;
            arm <= '0;
        end else begin
            arm <= '0;
            if (wr_en) begin
                for (int c = 0; c < NCH; c++) begin
                    if (addr == slot(PER_BASE, c)) begin
                        cfg[c].period <= wdata[CW-1:0];
                        arm[c]        <= 1'b1;
                    end
                    if (addr == slot(DUT_BASE, c)) cfg[c].duty <= wdata[CW-1:0];
                    if (addr == slot(CTL_BASE, c)) begin
                        cfg[c].div <= wdata[DIV_W-1:0];
                        cfg[c].inv <= wdata[INV_BIT];
                    end
                end
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == slot(PER_BASE, c)) rd_mux = DW'(cfg[c].period);
            if (addr == slot(DUT_BASE, c)) rd_mux = DW'(cfg[c].duty);
            if (addr == slot(CTL_BASE, c)) begin
                rd_mux[DIV_W-1:0] = cfg[c].div;
                rd_mux[INV_BIT]   = cfg[c].inv;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    AST_ARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arm)); // R2
    AST_ARM_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (arm == '0)); // R4
endmodule

// File: rtl/pwm_shadow_presc.sv
module pwm_shadow_presc
    import pwm_shadow_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             step
);
    logic [PW-1:0] pre;
    logic [PW-1:0] mask;

    assign mask = PW'((1 << div) - 1);
    assign step = tick && (pre == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pre <= '0;
        else if (clr)  pre <= '0;
        else if (tick) pre <= (pre == mask) ? '0 : pre + 1'b1;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(div) |=> (pre <= mask)); // R5
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
    import pwm_shadow_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  ch_cfg_t cfg,
    input  logic    arm,
    output logic    pwm
);
    ch_state_t     st, st_nx;
    ch_cfg_t       act;
    logic          pend;
    logic [CW-1:0] cnt;
    logic          step, last, load, stop;

    pwm_shadow_presc #(.PW(PW)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (load),
        .div  (act.div),
        .step (step)
    );

    assign last = (st == CH_RUN) && step && (cnt == act.period - 1'b1);

    // next state and commit decisions
    always_comb begin
        st_nx = st;
        load  = 1'b0;
        stop  = 1'b0;
        unique case (st)
            CH_IDLE: if (pend) begin
                if (cfg.period != '0) begin st_nx = CH_RUN; load = 1'b1; end
                else stop = 1'b1;
            end
            CH_RUN: if (last && pend) begin
                if (cfg.period == '0) begin st_nx = CH_IDLE; stop = 1'b1; end
                else load = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nx;
    end

    // datapath: pending flag, active settings, step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            act  <= '0;
            cnt  <= '0;
        end else begin
            if (arm)               pend <= 1'b1;
            else if (load || stop) pend <= 1'b0;
            if (load) begin
                act <= cfg;
                cnt <= '0;
            end else if (stop) begin
                cnt <= '0;
            end else if (st == CH_RUN && step) begin
                cnt <= last ? '0 : cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pwm = 1'b0;
        unique case (st)
            CH_IDLE: pwm = 1'b0;
            CH_RUN:  pwm = act.inv ^ (cnt < act.duty);
        endcase
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN) |-> (cnt < act.period)); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN && !last) |=> $stable(act)); // R4
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (last && pend && !arm && cfg.period == '0) |=> !pwm); // R8
    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN) |-> (act.period != '0)); // R9
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
    import pwm_shadow_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 12,
    parameter int DW  = 32,
    parameter int PW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    ch_cfg_t        cfg [NCH];
    logic [NCH-1:0] arm;

    pwm_shadow_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(bus_wr),
        .rd_en(bus_rd),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .rdata(bus_rdata),
        .cfg  (cfg),
        .arm  (arm)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_shadow_chan #(.PW(PW)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .cfg  (cfg[c]),
            .arm  (arm[c]),
            .pwm  (pwm_out[c])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0)); // R1
endmodule

// File: tb/pwm_shadow_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_shadow_ctrl_tb;
    localparam int TDIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int nchk = 0;
    int nerr = 0;

    pwm_shadow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    // timebase: one pulse every TDIV cycles
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            tick = (k == TDIV - 1);
            k = (k == TDIV - 1) ? 0 : k + 1;
        end
    end

    // run-length monitor
    int   run_len [4];
    int   last_hi [4];
    int   last_lo [4];
    int   nhi [4];
    int   nlo [4];
    logic prev [4];
    initial for (int c = 0; c < 4; c++) begin
        run_len[c] = 0; last_hi[c] = 0; last_lo[c] = 0; nhi[c] = 0; nlo[c] = 0; prev[c] = 1'b0;
    end
    always @(negedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (pwm_out[c] == prev[c]) run_len[c]++;
            else begin
                if (prev[c]) begin last_hi[c] = run_len[c]; nhi[c]++; end
                else begin last_lo[c] = run_len[c]; nlo[c]++; end
                run_len[c] = 1;
            end
            prev[c] = pwm_out[c];
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [11:0] a_per(input int c); return 12'h400 + 12'(4 * c); endfunction
    function automatic logic [11:0] a_dut(input int c); return 12'h420 + 12'(4 * c); endfunction
    function automatic logic [11:0] a_ctl(input int c); return 12'h440 + 12'(4 * c); endfunction
    function automatic logic [31:0] ctl_word(input int dv, input bit inv);
        return (32'(inv) << 5) | 32'(dv & 3);
    endfunction
    function automatic int step_len(input int dv); return (1 << dv) * TDIV; endfunction
    function automatic int exp_active(input int p, input int d, input int dv);
        return ((d > p) ? p : d) * step_len(dv);
    endfunction

    task automatic cfg_ch(input int c, input int p, input int d, input int dv, input bit inv);
        wr(a_ctl(c), 32'hFFFF_FF00 | 32'h1C | ctl_word(dv, inv) ^ 32'h0000_0000);
        wr(a_dut(c), 32'h5A5A_0000 | 32'(d));
        wr(a_per(c), 32'hA5A5_0000 | 32'(p));
    endtask

    task automatic wait_hi(input int c, output int len);
        int k = nhi[c];
        int g = 0;
        do begin @(negedge clk); #1; g++; end while (nhi[c] == k && g < 3000);
        len = last_hi[c];
    endtask

    task automatic wait_lo(input int c, output int len);
        int k = nlo[c];
        int g = 0;
        do begin @(negedge clk); #1; g++; end while (nlo[c] == k && g < 3000);
        len = last_lo[c];
    endtask

    task automatic count_active(input int c, input bit inv, input int win, output int n);
        n = 0;
        repeat (win) begin
            @(negedge clk);
            if (pwm_out[c] == !inv) n++;
        end
    endtask

    initial begin
        logic [31:0] d;
        int h, l, n;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(pwm_out == 4'b0, "R1 outputs low in reset", pwm_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == 4'b0, "R1 outputs low after reset", pwm_out, 0);
        rd(a_per(0), d); chk(d == 0, "R1 period ch0 reset", d, 0);
        rd(a_ctl(3), d); chk(d == 0, "R1 control ch3 reset", d, 0);
        rd(a_dut(2), d); chk(d == 0, "R1 duty ch2 reset", d, 0);
        rd(12'h460, d);  chk(d == 0, "R2 unmapped 0x460", d, 0);

        // R9: idle start
        cfg_ch(0, 8, 4, 0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R9 idle start two cycles after write", pwm_out[0], 1);

        // R6 run lengths
        wait_hi(0, h); wait_hi(0, h);
        chk(h == 12, "R6 high run P8 D4", h, 12);
        wait_lo(0, l);
        chk(l == 12, "R6 low run P8 D4", l, 12);

        // R3: duty and control without period write
        wr(a_ctl(0), ctl_word(2, 1'b1));
        wr(a_dut(0), 32'd2);
        wait_hi(0, h); chk(h == 12, "R3 unarmed duty/control ignored (high)", h, 12);
        wait_lo(0, l); chk(l == 12, "R3 unarmed duty/control ignored (low)", l, 12);
        wait_hi(0, h); chk(h == 12, "R3 unarmed duty/control ignored (high2)", h, 12);

        // R4: arm at frame start, commit only at frame end
        wait_lo(0, l);
        wr(a_ctl(0), ctl_word(0, 1'b0));
        wr(a_dut(0), 32'd6);
        wr(a_per(0), 32'd8);
        wait_hi(0, h); chk(h == 12, "R4 running frame keeps old duty", h, 12);
        wait_hi(0, h); chk(h == 18, "R4 next frame uses new duty", h, 18);
        wait_lo(0, l); chk(l == 6, "R4 new low run", l, 6);

        // R5 dividers
        cfg_ch(1, 5, 2, 2, 1'b0);
        wait_hi(1, h); wait_hi(1, h);
        chk(h == 24, "R5 div2 high run", h, 24);
        wait_lo(1, l); chk(l == 36, "R5 div2 low run", l, 36);
        cfg_ch(2, 3, 1, 3, 1'b0);
        wait_hi(2, h); wait_hi(2, h);
        chk(h == 24, "R5 div3 high run", h, 24);
        wait_lo(2, l); chk(l == 48, "R5 div3 low run", l, 48);

        // R7 polarity
        cfg_ch(3, 6, 2, 0, 1'b1);
        wait_hi(3, h); wait_hi(3, h);
        chk(h == 12, "R7 inverted inactive high run", h, 12);
        wait_lo(3, l); chk(l == 6, "R7 inverted active low run", l, 6);
        rd(a_ctl(3), d); chk(d == 32'h20, "R2 control readback masks bits", d, 32'h20);
        rd(a_per(3), d); chk(d == 6, "R2 period readback low 16 bits", d, 6);

        // R8 deferred stop on inverted channel, during its high phase
        wait_lo(3, l);
        wr(a_per(3), 32'd0);
        @(negedge clk);
        chk(pwm_out[3] == 1'b1, "R8 frame completes before stop", pwm_out[3], 1);
        repeat (20) @(negedge clk);
        count_active(3, 1'b1, 100, n);
        chk(n == 100, "R8 stopped output held low", n, 100);
        rd(a_per(3), d); chk(d == 0, "R2 period readback zero", d, 0);

        // R10 other channels untouched by ch3 traffic
        wait_hi(0, h); chk(h == 18, "R10 ch0 high run unaffected", h, 18);
        wait_lo(0, l); chk(l == 6, "R10 ch0 low run unaffected", l, 6);
        wait_hi(1, h); chk(h == 24, "R10 ch1 high run unaffected", h, 24);

        // R6 boundaries
        cfg_ch(2, 4, 9, 0, 1'b0);
        cfg_ch(1, 4, 0, 0, 1'b0);
        repeat (400) @(negedge clk);
        count_active(2, 1'b0, 4 * TDIV, n);
        chk(n == 4 * TDIV, "R6 duty above period always high", n, 4 * TDIV);
        count_active(1, 1'b0, 4 * TDIV, n);
        chk(n == 0, "R6 duty zero never high", n, 0);

        // random frames
        for (int it = 0; it < 12; it++) begin
            int c  = int'($urandom % 4);
            int p  = 1 + int'($urandom % 12);
            int du = int'($urandom % 14);
            int dv = int'($urandom % 4);
            bit iv = 1'($urandom % 2);
            cfg_ch(c, p, du, dv, iv);
            rd(a_per(c), d); chk(d == 32'(p), "R2 random period readback", d, p);
            rd(a_dut(c), d); chk(d == 32'(du), "R2 random duty readback", d, du);
            rd(a_ctl(c), d); chk(d == ctl_word(dv, iv), "R2 random control readback", d, ctl_word(dv, iv));
            repeat (600) @(negedge clk);
            count_active(c, iv, p * step_len(dv), n);
            chk(n == exp_active(p, du, dv), iv ? "R7 random inverted active time" : "R6 random active time",
                n, exp_active(p, du, dv));
        end

        summary();
        $finish;
    end
endmodule